// File: doc/BRIEF.md
# Dual-Width Timer/Counter with Input Capture

This block is a general-purpose timer for a small controller. It runs either as an 8-bit counter with two independent compare channels, or as a 16-bit counter with one compare channel. In 16-bit mode the two 8-bit compare registers join into a single compare word, and a high count byte comes into use. Each count step comes from one of two sources, picked by a control bit: a prescaled tick supplied from outside, or rising edges seen on an external pin after synchronisation. Clear-on-match turns the counter into an auto-reloading period generator.

An input-capture path latches the running count when a chosen edge arrives. The trigger is either a capture pin or a comparator output. It passes through a synchroniser, an optional majority-free glitch filter that needs several equal samples, and an edge detector with selectable polarity. Four event flags (overflow, compare A, compare B, capture) are each gated by a mask bit onto an interrupt line. Software reaches everything through a byte-wide register bus. A shared temporary byte makes 16-bit reads and writes atomic.

Top module: `dual_width_timer`

## Requirements
- R1: With control bit 0 (wide) clear, the counter is 8 bits. It steps 0xFF to 0x00, the high count byte (address 2) reads 0x00, and a step taken at 0xFF sets the overflow flag (flag bit 0).
- R2: In 8-bit mode, a step taken while the count equals compare A (address 3) sets flag bit 1. A step taken while it equals compare B (address 4) sets flag bit 2. The two are independent.
- R3: With the wide bit set, the compare value is {compare B, compare A}. Only flag bit 1 can be set by a match, flag bit 2 never sets, and overflow sets on a step taken at 0xFFFF.
- R4: With control bit 1 (clear-on-match) set, a step taken while the count equals the active compare value loads 0 instead of count+1.
- R5: Control bit 2 clear makes each cycle with tick_i high a step. Set, it makes each synchronised rising edge of ext_clk_i a step. The source not selected has no effect on the count.
- R6: Flags (address 7) are cleared by writing 1 to a bit. A flag set by an event in the same cycle as its clear stays set.
- R7: irq_o equals flag bits ANDed with mask bits (address 8).
- R8: A capture edge copies the count into the capture register (low byte at address 5, high at 6) and sets flag bit 3. Control bit 3 set selects rising edges and clear selects falling edges. The other edge captures nothing.
- R9: Control bit 4 clear takes the capture trigger from cap_pin_i. Set, it takes it from cmp_in_i. The trigger not selected captures nothing.
- R10: With control bit 5 set, the filtered trigger changes only after 4 consecutive equal synchronised samples, so a 3-cycle pulse is rejected. With the bit clear, a 2-cycle pulse is captured.
- R11: In wide mode, reading address 1 (or 5) copies the high count (or capture) byte into a temporary byte, and reading address 2 (or 6) returns that byte. Writing address 2 only loads the temporary byte. Writing address 1 commits {temporary, data} to the counter.
- R12: After reset every register reads 0x00 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaled count tick |
| ext_clk_i | input | 1 | External count pin (asynchronous) |
| cap_pin_i | input | 1 | Capture pin (asynchronous) |
| cmp_in_i | input | 1 | Comparator output used as capture trigger |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (drives temporary-byte snapshots) |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_o | output | 4 | Masked interrupt requests, one per flag |

## Verification
The counting core is driven through a table of start values, compare pairs and step counts. The table places 8-bit and 16-bit runs over the same low-byte values, so a wrong width, a wrong overflow point or a stray compare B match shows up as a different count or flag pattern. Clear-on-match vectors put the match on the maximum value as well as mid-range, which separates reload from wrap. Capture is tried with both polarities, both trigger sources, and pulses just under and over the filter length. These show that an unselected edge or source has no effect and that the filter setting changes what is accepted.

// File: rtl/dwt_pkg.sv
package dwt_pkg;
   localparam logic [3:0] REG_CTRL = 4'd0;
   localparam logic [3:0] REG_CNTL = 4'd1;
   localparam logic [3:0] REG_CNTH = 4'd2;
   localparam logic [3:0] REG_CMPA = 4'd3;
   localparam logic [3:0] REG_CMPB = 4'd4;
   localparam logic [3:0] REG_CAPL = 4'd5;
   localparam logic [3:0] REG_CAPH = 4'd6;
   localparam logic [3:0] REG_FLAG = 4'd7;
   localparam logic [3:0] REG_MASK = 4'd8;

   localparam int FLG_OVF = 0;
   localparam int FLG_CMA = 1;
   localparam int FLG_CMB = 2;
   localparam int FLG_CAP = 3;
   localparam int NUM_FLG = 4;

   typedef struct packed {
      logic [1:0] spare;
      logic       filt_en;
      logic       cap_from_cmp;
      logic       cap_rise;
      logic       ext_src;
      logic       clr_match;
      logic       wide;
   } ctrl_t;
endpackage

// File: rtl/dwt_sync.sv
module dwt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dwt_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dwt_glitch_filter.sv
module dwt_glitch_filter #(
   parameter int FILT_LEN = 4,
   parameter bit PRESENT  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   input  logic en_i,
   output logic q_o
);
   generate
      if (FILT_LEN < 2) begin : g_bad_len
         $error("dwt_glitch_filter: FILT_LEN must be at least 2");
      end

      if (PRESENT) begin : g_filter
         logic [FILT_LEN-1:0] hist_q;
         logic                filt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist_q <= '0;
               filt_q <= 1'b0;
            end else begin
               hist_q <= {hist_q[FILT_LEN-2:0], d_i};
               if (&hist_q)       filt_q <= 1'b1;
               else if (~|hist_q) filt_q <= 1'b0;
            end
         end

         assign q_o = en_i ? filt_q : d_i;

         // R10: mixed history leaves the filtered level untouched
         a_r10_filter_hold: assert property (@(posedge clk) disable iff (!rst_n)
            ((|hist_q) && !(&hist_q)) |=> $stable(filt_q));
      end else begin : g_bypass
         assign q_o = d_i;
      end
   endgenerate
endmodule

// File: rtl/dwt_edge_det.sv
module dwt_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   input  logic rise_sel_i,
   output logic ev_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= d_i;
   end

   assign ev_o = rise_sel_i ? (d_i & ~prev_q) : (~d_i & prev_q);
endmodule

// File: rtl/dual_width_timer.sv
module dual_width_timer
   import dwt_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 4,
   parameter bit HAS_FILTER  = 1'b1,
   parameter int BYTE_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              ext_clk_i,
   input  logic              cap_pin_i,
   input  logic              cmp_in_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [3:0]        addr_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [BYTE_W-1:0] rdata_o,
   output logic [3:0]        irq_o
);
   localparam int WORD_W = 2 * BYTE_W;

   generate
      if (BYTE_W != 8) begin : g_bad_width
         $error("dual_width_timer: register map assumes BYTE_W == 8");
      end
   endgenerate

   ctrl_t               ctrl_q;
   logic [WORD_W-1:0]   cnt_q, cnt_d, cap_q, cmp_word, cnt_inc;
   logic [BYTE_W-1:0]   cmpa_q, cmpb_q, tmp_q;
   logic [NUM_FLG-1:0]  flg_q, msk_q, flg_set, flg_clr;

   // register bus decode
   logic wr_ctrl, wr_cntl, wr_cnth, wr_cmpa, wr_cmpb, wr_flag, wr_mask;
   assign wr_ctrl = wr_en_i && (addr_i == REG_CTRL);
   assign wr_cntl = wr_en_i && (addr_i == REG_CNTL);
   assign wr_cnth = wr_en_i && (addr_i == REG_CNTH);
   assign wr_cmpa = wr_en_i && (addr_i == REG_CMPA);
   assign wr_cmpb = wr_en_i && (addr_i == REG_CMPB);
   assign wr_flag = wr_en_i && (addr_i == REG_FLAG);
   assign wr_mask = wr_en_i && (addr_i == REG_MASK);

   // external count clock: synchronise, then take rising edges
   logic ext_sync, ext_rise;
   dwt_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
      .clk(clk), .rst_n(rst_n), .d_i(ext_clk_i), .q_o(ext_sync));
   dwt_edge_det u_ext_edge (
      .clk(clk), .rst_n(rst_n), .d_i(ext_sync), .rise_sel_i(1'b1), .ev_o(ext_rise));

   // capture trigger: source select, synchronise, filter, edge
   logic cap_src, cap_sync, cap_filt, cap_evt;
   assign cap_src = ctrl_q.cap_from_cmp ? cmp_in_i : cap_pin_i;
   dwt_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
      .clk(clk), .rst_n(rst_n), .d_i(cap_src), .q_o(cap_sync));
   dwt_glitch_filter #(.FILT_LEN(FILT_LEN), .PRESENT(HAS_FILTER)) u_cap_filt (
      .clk(clk), .rst_n(rst_n), .d_i(cap_sync), .en_i(ctrl_q.filt_en), .q_o(cap_filt));
   dwt_edge_det u_cap_edge (
      .clk(clk), .rst_n(rst_n), .d_i(cap_filt), .rise_sel_i(ctrl_q.cap_rise), .ev_o(cap_evt));

   // counting core
   logic step_eff, hit_a, hit_b, at_max;
   assign step_eff = (ctrl_q.ext_src ? ext_rise : tick_i) && !wr_cntl;
   assign cmp_word = {cmpb_q, cmpa_q};
   assign hit_a    = ctrl_q.wide ? (cnt_q == cmp_word) : (cnt_q[BYTE_W-1:0] == cmpa_q);
   assign hit_b    = !ctrl_q.wide && (cnt_q[BYTE_W-1:0] == cmpb_q);
   assign at_max   = ctrl_q.wide ? (&cnt_q) : (&cnt_q[BYTE_W-1:0]);
   assign cnt_inc  = ctrl_q.wide ? cnt_q + 1'b1
                                 : {{BYTE_W{1'b0}}, cnt_q[BYTE_W-1:0] + 1'b1};

   always_comb begin
      cnt_d = cnt_q;
      if (wr_cntl)
         cnt_d = ctrl_q.wide ? {tmp_q, wdata_i} : {{BYTE_W{1'b0}}, wdata_i};
      else if (step_eff)
         cnt_d = (ctrl_q.clr_match && hit_a) ? '0 : cnt_inc;
   end

   // event flags: set wins over write-one-to-clear
   always_comb begin
      flg_set          = '0;
      flg_set[FLG_OVF] = step_eff && at_max;
      flg_set[FLG_CMA] = step_eff && hit_a;
      flg_set[FLG_CMB] = step_eff && hit_b;
      flg_set[FLG_CAP] = cap_evt;
      flg_clr          = wr_flag ? wdata_i[NUM_FLG-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         cnt_q  <= '0;
         cmpa_q <= '0;
         cmpb_q <= '0;
         cap_q  <= '0;
         tmp_q  <= '0;
         flg_q  <= '0;
         msk_q  <= '0;
      end else begin
         cnt_q <= cnt_d;
         flg_q <= (flg_q & ~flg_clr) | flg_set;
         if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i);
         if (wr_cmpa) cmpa_q <= wdata_i;
         if (wr_cmpb) cmpb_q <= wdata_i;
         if (wr_mask) msk_q  <= wdata_i[NUM_FLG-1:0];
         if (cap_evt) cap_q  <= cnt_q;
         if (wr_cnth)
            tmp_q <= wdata_i;
         else if (rd_en_i && ctrl_q.wide && addr_i == REG_CNTL)
            tmp_q <= cnt_q[WORD_W-1:BYTE_W];
         else if (rd_en_i && ctrl_q.wide && addr_i == REG_CAPL)
            tmp_q <= cap_q[WORD_W-1:BYTE_W];
      end
   end

   // read mux
   always_comb begin
      unique case (addr_i)
         REG_CTRL: rdata_o = ctrl_q;
         REG_CNTL: rdata_o = cnt_q[BYTE_W-1:0];
         REG_CNTH: rdata_o = ctrl_q.wide ? tmp_q : '0;
         REG_CMPA: rdata_o = cmpa_q;
         REG_CMPB: rdata_o = cmpb_q;
         REG_CAPL: rdata_o = cap_q[BYTE_W-1:0];
         REG_CAPH: rdata_o = ctrl_q.wide ? tmp_q : '0;
         REG_FLAG: rdata_o = {{(BYTE_W-NUM_FLG){1'b0}}, flg_q};
         REG_MASK: rdata_o = {{(BYTE_W-NUM_FLG){1'b0}}, msk_q};
         default:  rdata_o = '0;
      endcase
   end

   assign irq_o = flg_q & msk_q;

   // assertions
   generate
      for (genvar i = 0; i < NUM_FLG; i++) begin : g_flag_chk
         // R6: a raised flag persists until software writes 1 to it
         a_r6_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (flg_q[i] && !(wr_flag && wdata_i[i])) |=> flg_q[i]);
      end
   endgenerate

   // R1: narrow steps never leave anything in the high count byte
   a_r1_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.wide && step_eff) |=> (cnt_q[WORD_W-1:BYTE_W] == '0));

   // R3: compare B is silent while the counter is wide
   a_r3_no_b_in_wide: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.wide && !wr_ctrl && !flg_q[FLG_CMB]) |=> !flg_q[FLG_CMB]);

   // R4: a matching step with clear-on-match reloads zero
   a_r4_clear_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (step_eff && ctrl_q.clr_match && hit_a) |=> (cnt_q == '0));

   // R8: every capture edge raises the capture flag
   a_r8_capture_sets: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> flg_q[FLG_CAP]);
endmodule

// File: tb/tb_dual_width_timer.sv
module tb_dual_width_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0, ext_clk_i = 1'b0, cap_pin_i = 1'b0, cmp_in_i = 1'b0;
   logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
   logic [3:0] addr_i = '0;
   logic [7:0] wdata_i = '0;
   logic [7:0] rdata_o;
   logic [3:0] irq_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   dual_width_timer dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ext_clk_i(ext_clk_i),
      .cap_pin_i(cap_pin_i), .cmp_in_i(cmp_in_i), .wr_en_i(wr_en_i),
      .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
      .rdata_o(rdata_o), .irq_o(irq_o));

   typedef struct packed {
      logic [7:0]  ctrl;
      logic [7:0]  cmpa;
      logic [7:0]  cmpb;
      logic [15:0] start;
      logic [7:0]  steps;
      logic [15:0] exp_cnt;
      logic [3:0]  exp_flg;
   } vec_t;

   // ctrl bit0 wide, bit1 clear-on-match; flags bit0 ovf, bit1 A, bit2 B
   localparam vec_t VECS [8] = '{
      '{8'h00, 8'h10, 8'h20, 16'h0005, 8'd3, 16'h0008, 4'h0},  // R1 plain count
      '{8'h00, 8'h06, 8'h07, 16'h0005, 8'd4, 16'h0009, 4'h6},  // R2 both compares
      '{8'h00, 8'h00, 8'h00, 16'h00FE, 8'd3, 16'h0001, 4'h7},  // R1 wrap + R2
      '{8'h02, 8'h07, 8'h50, 16'h0005, 8'd4, 16'h0001, 4'h2},  // R4 narrow reload
      '{8'h01, 8'h00, 8'h01, 16'h00FE, 8'd4, 16'h0102, 4'h2},  // R3 no ovf at FF
      '{8'h01, 8'h34, 8'hFF, 16'hFFFE, 8'd3, 16'h0001, 4'h1},  // R3 ovf at FFFF, B silent
      '{8'h03, 8'h02, 8'h01, 16'h0101, 8'd3, 16'h0001, 4'h2},  // R4 wide reload
      '{8'h02, 8'hFF, 8'h00, 16'h00FE, 8'd3, 16'h0001, 4'h7}   // R4 match at max
   };

   task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; addr_i = a; wdata_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_en_i = 1'b1; addr_i = a;
      #1 d = rdata_o;
      @(negedge clk);
      rd_en_i = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick_i = 1'b1;
         @(negedge clk); tick_i = 1'b0;
      end
   endtask

   task automatic set_cnt(input logic [15:0] v);
      wr(4'd2, v[15:8]);
      wr(4'd1, v[7:0]);
   endtask

   task automatic pin_pulse(input int hi, input int lo);
      @(negedge clk); cap_pin_i = 1'b1;
      repeat (hi) @(negedge clk);
      cap_pin_i = 1'b0;
      repeat (lo) @(negedge clk);
   endtask

   task automatic ext_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ext_clk_i = 1'b1;
         repeat (3) @(negedge clk);
         ext_clk_i = 1'b0;
         repeat (3) @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] lo, hi, fl;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R12: reset state
      for (int a = 0; a < 9; a++) begin
         rd(4'(a), lo);
         chk($sformatf("R12 reset reg %0d", a), {8'h0, lo}, 16'h0000);
      end
      chk("R12 reset irq", {12'h0, irq_o}, 16'h0000);

      // counting table (R1 R2 R3 R4)
      foreach (VECS[k]) begin
         wr(4'd0, VECS[k].ctrl);
         wr(4'd3, VECS[k].cmpa);
         wr(4'd4, VECS[k].cmpb);
         set_cnt(VECS[k].start);
         wr(4'd7, 8'h0F);
         ticks(int'(VECS[k].steps));
         rd(4'd1, lo);
         rd(4'd2, hi);
         rd(4'd7, fl);
         chk($sformatf("R1 R2 R3 R4 vector %0d count", k), {hi, lo}, VECS[k].exp_cnt);
         chk($sformatf("R1 R2 R3 R4 vector %0d flags", k), {8'h0, fl}, {12'h0, VECS[k].exp_flg});
      end

      // R7: masking (flags are 0x7 after last vector)
      wr(4'd8, 8'h02);
      #1 chk("R7 irq with mask 0x2", {12'h0, irq_o}, 16'h0002);
      wr(4'd8, 8'h0F);
      #1 chk("R7 irq with mask 0xF", {12'h0, irq_o}, 16'h0007);

      // R6: clear and set-priority
      wr(4'd7, 8'h01);
      rd(4'd7, fl);
      chk("R6 write-one clears ovf only", {8'h0, fl}, 16'h0006);
      wr(4'd0, 8'h00);
      wr(4'd3, 8'h10);
      wr(4'd4, 8'h10);
      set_cnt(16'h00FF);
      wr(4'd7, 8'h0F);
      @(negedge clk);
      tick_i = 1'b1; wr_en_i = 1'b1; addr_i = 4'd7; wdata_i = 8'h01;
      @(negedge clk);
      tick_i = 1'b0; wr_en_i = 1'b0;
      rd(4'd7, fl);
      chk("R6 set beats same-cycle clear", {8'h0, fl}, 16'h0001);

      // R11: atomic 16-bit access
      wr(4'd0, 8'h01);
      set_cnt(16'h12FF);
      rd(4'd1, lo);
      ticks(1);
      rd(4'd2, hi);
      chk("R11 high byte snapshot on low read", {hi, lo}, 16'h12FF);
      rd(4'd1, lo);
      rd(4'd2, hi);
      chk("R11 count after step", {hi, lo}, 16'h1300);
      wr(4'd2, 8'hAB);
      rd(4'd1, lo);
      rd(4'd2, hi);
      chk("R11 high write alone not committed", {hi, lo}, 16'h1300);
      wr(4'd2, 8'hAB);
      wr(4'd1, 8'hCD);
      rd(4'd1, lo);
      rd(4'd2, hi);
      chk("R11 paired write commits", {hi, lo}, 16'hABCD);

      // R5: external source counts pin edges, ignores tick
      wr(4'd0, 8'h04);
      set_cnt(16'h0000);
      @(negedge clk); tick_i = 1'b1;
      ext_pulses(3);
      tick_i = 1'b0;
      repeat (6) @(negedge clk);
      rd(4'd1, lo);
      chk("R5 external edges counted, tick ignored", {8'h0, lo}, 16'h0003);
      wr(4'd0, 8'h00);
      ext_pulses(3);
      repeat (6) @(negedge clk);
      rd(4'd1, lo);
      chk("R5 pin ignored on tick source", {8'h0, lo}, 16'h0003);

      // R8: rising capture in wide mode
      wr(4'd0, 8'h09);
      set_cnt(16'h3456);
      wr(4'd7, 8'h0F);
      pin_pulse(10, 10);
      rd(4'd7, fl);
      chk("R8 rising capture flag", {8'h0, fl}, 16'h0008);
      rd(4'd5, lo);
      rd(4'd6, hi);
      chk("R8 R11 captured word", {hi, lo}, 16'h3456);

      // R8: falling polarity
      wr(4'd0, 8'h00);
      set_cnt(16'h0055);
      wr(4'd7, 8'h0F);
      @(negedge clk); cap_pin_i = 1'b1;
      repeat (8) @(negedge clk);
      rd(4'd7, fl);
      chk("R8 rising edge ignored with falling select", {8'h0, fl}, 16'h0000);
      cap_pin_i = 1'b0;
      repeat (8) @(negedge clk);
      rd(4'd7, fl);
      chk("R8 falling capture flag", {8'h0, fl}, 16'h0008);
      rd(4'd5, lo);
      chk("R8 falling capture value", {8'h0, lo}, 16'h0055);

      // R9: comparator as capture source
      wr(4'd0, 8'h18);
      set_cnt(16'h0066);
      wr(4'd7, 8'h0F);
      pin_pulse(8, 8);
      rd(4'd7, fl);
      chk("R9 pin ignored when comparator selected", {8'h0, fl}, 16'h0000);
      @(negedge clk); cmp_in_i = 1'b1;
      repeat (8) @(negedge clk);
      cmp_in_i = 1'b0;
      repeat (8) @(negedge clk);
      rd(4'd7, fl);
      chk("R9 comparator capture flag", {8'h0, fl}, 16'h0008);
      rd(4'd5, lo);
      chk("R9 comparator capture value", {8'h0, lo}, 16'h0066);

      // R10: noise filter
      wr(4'd0, 8'h28);
      repeat (8) @(negedge clk);
      set_cnt(16'h0077);
      wr(4'd7, 8'h0F);
      pin_pulse(3, 10);
      rd(4'd7, fl);
      chk("R10 3-cycle pulse rejected", {8'h0, fl}, 16'h0000);
      pin_pulse(10, 10);
      rd(4'd7, fl);
      chk("R10 long pulse accepted", {8'h0, fl}, 16'h0008);
      rd(4'd5, lo);
      chk("R10 filtered capture value", {8'h0, lo}, 16'h0077);
      wr(4'd0, 8'h08);
      set_cnt(16'h0021);
      wr(4'd7, 8'h0F);
      pin_pulse(2, 10);
      rd(4'd7, fl);
      chk("R10 2-cycle pulse captured unfiltered", {8'h0, fl}, 16'h0008);
      rd(4'd5, lo);
      chk("R10 unfiltered capture value", {8'h0, lo}, 16'h0021);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule